// File: doc/BRIEF.md
# Sub-Line Transactional Ownership Tracker

This block keeps ownership state for a single 64-byte cache line on behalf of up to `2**TAG_W - 1` hardware transactions that run at the same time. The line is cut into equal chunks of `CHUNK_BITS` bits. Each chunk carries a small owner tag, and the tag value zero marks a chunk that no transaction holds. A store request presents a transaction ID and a per-byte enable mask. The block works out which chunks the mask touches and checks each of them against its current owner. If none of them clashes, the store claims the touched chunks. If any of them clashes, the block raises a conflict and reports who the rival is.

Commit and abort requests both release every chunk held by the named ID in a single cycle. Two transactions can therefore write neighbouring words of the same line without disturbing each other. Only a real overlap on a chunk is flagged. The surrounding cache controller or load/store unit drives the requests and acts on the registered conflict result, for example by aborting the requester.

The chunk size (8, 16, 32, 64 or 128 bits) and the tag width are parameters. The default is 32-bit chunks with 2-bit tags, which gives 16 chunks and three usable transaction IDs.

Top module: `subline_tx_tracker`

## Requirements
- R1: After reset every tag is 0, and `conflict_o` and `conflict_owner_o` are 0.
- R2: Chunk i covers byte enables `wr_be[i*CHUNK_BYTES +: CHUNK_BYTES]`, and its tag sits at `tag_vec_o[i*TAG_W +: TAG_W]`. A store with a nonzero ID is accepted without conflict when every chunk it touches is unowned or already carries that ID. Each touched chunk then takes the ID.
- R3: Stores from different IDs to disjoint chunks of the line never raise a conflict.
- R4: A store that touches a chunk owned by a different nonzero ID raises `conflict_o`. `conflict_owner_o` then carries that owner's ID, and no tag changes.
- R5: When a store touches several chunks and at least one of them clashes, the reported owner is the one held by the lowest-index clashing chunk. None of the touched chunks changes its tag, including chunks that are free.
- R6: A store with ID 0 is non-transactional. It raises a conflict if any chunk it touches is owned, with the lowest-index owner reported. It never changes a tag.
- R7: A commit or an abort for ID X clears every tag equal to X in one cycle and leaves all other tags alone. A commit and an abort in the same cycle are both applied.
- R8: A store with an all-zero byte-enable mask raises no conflict and changes no tag.
- R9: `conflict_o` and `conflict_owner_o` are registered. They reflect the store presented in the previous cycle, and both are 0 in the cycle after a cycle with no store.
- R10: When a store and a release arrive in the same cycle, the conflict decision uses the tags held before that cycle. The release is applied, and the tags claimed by a store with no conflict win over the release on the chunks the store touches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Store request present |
| wr_id | input | TAG_W | Transaction ID of the store (0 = non-transactional) |
| wr_be | input | LINE_BYTES | Per-byte enable mask over the line |
| commit_valid | input | 1 | Commit request present |
| commit_id | input | TAG_W | ID being committed |
| abort_valid | input | 1 | Abort request present |
| abort_id | input | TAG_W | ID being aborted |
| conflict_o | output | 1 | Previous-cycle store clashed with an owner |
| conflict_owner_o | output | TAG_W | ID of the lowest-index clashing owner, 0 when no conflict |
| tag_vec_o | output | NCHUNK*TAG_W | Current owner tag of every chunk |

## Verification
The hardest state to reach from the ports is a store that meets a release of its rival in the same cycle. The conflict must be judged on the old tags, while the tag vector must show the release. To get there, the stimulus first sets up chunks held by two IDs. It then presents a store and an abort on the same clock edge and checks the flag, the owner and the whole tag vector one cycle later. A second hard case is a multi-chunk mask that spans free chunks and chunks held by two different owners. This case shows both the lowest-index owner selection and the rule that the whole store is rejected.

// File: rtl/stt_pkg.sv
package stt_pkg;

  localparam int MAX_TAG_W = 8;

  // A chunk clashes when it is owned and the owner is not the requester.
  function automatic logic owner_clash(input logic [MAX_TAG_W-1:0] req_id,
                                       input logic [MAX_TAG_W-1:0] owner);
    return (owner != '0) && (owner != req_id);
  endfunction

  // Number of chunks in a line of line_bytes for a chunk of chunk_bits.
  function automatic int chunk_count(input int line_bytes, input int chunk_bits);
    return (line_bytes * 8) / chunk_bits;
  endfunction

endpackage

// File: rtl/stt_chunk_map.sv
module stt_chunk_map #(
  parameter int LINE_BYTES  = 64,
  parameter int CHUNK_BYTES = 4,
  parameter int NCHUNK      = LINE_BYTES / CHUNK_BYTES
) (
  input  logic [LINE_BYTES-1:0] be,
  output logic [NCHUNK-1:0]     touched
);

  for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
    assign touched[g] = |be[g*CHUNK_BYTES +: CHUNK_BYTES];
  end

endmodule

// File: rtl/stt_clash_scan.sv
module stt_clash_scan
  import stt_pkg::*;
#(
  parameter int NCHUNK = 16,
  parameter int TAG_W  = 2
) (
  input  logic [NCHUNK-1:0]       touched,
  input  logic [NCHUNK*TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]        req_id,
  output logic                    hit_any,
  output logic [TAG_W-1:0]        first_owner
);

  logic [NCHUNK-1:0] hit;

  for (genvar g = 0; g < NCHUNK; g++) begin : g_hit
    assign hit[g] = touched[g] &&
                    owner_clash(MAX_TAG_W'(req_id), MAX_TAG_W'(tags[g*TAG_W +: TAG_W]));
  end

  assign hit_any = |hit;

  // Scan from the top down so the lowest-index hit is the last to be assigned.
  always_comb begin
    first_owner = '0;
    for (int i = NCHUNK - 1; i >= 0; i--) begin
      if (hit[i]) first_owner = tags[i*TAG_W +: TAG_W];
    end
  end

endmodule

// File: rtl/stt_tag_store.sv
module stt_tag_store #(
  parameter int NCHUNK = 16,
  parameter int TAG_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    claim_en,
  input  logic [NCHUNK-1:0]       claim_mask,
  input  logic [TAG_W-1:0]        claim_id,
  input  logic                    rel0_en,
  input  logic [TAG_W-1:0]        rel0_id,
  input  logic                    rel1_en,
  input  logic [TAG_W-1:0]        rel1_id,
  output logic [NCHUNK*TAG_W-1:0] tags_flat
);

  logic [TAG_W-1:0] tag_q [NCHUNK];
  logic [TAG_W-1:0] tag_d [NCHUNK];

  always_comb begin
    for (int i = 0; i < NCHUNK; i++) begin
      tag_d[i] = tag_q[i];
      if (rel0_en && tag_q[i] == rel0_id) tag_d[i] = '0;
      if (rel1_en && tag_q[i] == rel1_id) tag_d[i] = '0;
      if (claim_en && claim_mask[i])      tag_d[i] = claim_id;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCHUNK; i++) tag_q[i] <= '0;
    end else begin
      for (int i = 0; i < NCHUNK; i++) tag_q[i] <= tag_d[i];
    end
  end

  for (genvar g = 0; g < NCHUNK; g++) begin : g_out
    assign tags_flat[g*TAG_W +: TAG_W] = tag_q[g];

    AST_CLAIM_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_q[g] != '0 && !$stable(tag_q[g])) |-> $past(claim_en && claim_mask[g])); // R6

    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rel0_en) && $past(tag_q[g]) == $past(rel0_id) && $past(tag_q[g]) != '0
       && !$past(claim_en && claim_mask[g])) |-> tag_q[g] == '0); // R7
  end

endmodule

// File: rtl/subline_tx_tracker.sv
module subline_tx_tracker
  import stt_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int CHUNK_BITS = 32,
  parameter int TAG_W      = 2
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     wr_valid,
  input  logic [TAG_W-1:0]                         wr_id,
  input  logic [LINE_BYTES-1:0]                    wr_be,
  input  logic                                     commit_valid,
  input  logic [TAG_W-1:0]                         commit_id,
  input  logic                                     abort_valid,
  input  logic [TAG_W-1:0]                         abort_id,
  output logic                                     conflict_o,
  output logic [TAG_W-1:0]                         conflict_owner_o,
  output logic [(LINE_BYTES*8/CHUNK_BITS)*TAG_W-1:0] tag_vec_o
);

  localparam int CHUNK_BYTES = CHUNK_BITS / 8;
  localparam int NCHUNK      = chunk_count(LINE_BYTES, CHUNK_BITS);

  logic [NCHUNK-1:0] touched;
  logic              hit_any;
  logic [TAG_W-1:0]  first_owner;
  logic              claim_en;
  logic              clash_now;
  logic              conflict_q;
  logic [TAG_W-1:0]  owner_q;

  stt_chunk_map #(
    .LINE_BYTES (LINE_BYTES),
    .CHUNK_BYTES(CHUNK_BYTES),
    .NCHUNK     (NCHUNK)
  ) u_map (
    .be     (wr_be),
    .touched(touched)
  );

  stt_clash_scan #(
    .NCHUNK(NCHUNK),
    .TAG_W (TAG_W)
  ) u_scan (
    .touched    (touched),
    .tags       (tag_vec_o),
    .req_id     (wr_id),
    .hit_any    (hit_any),
    .first_owner(first_owner)
  );

  assign clash_now = wr_valid && hit_any;
  assign claim_en  = wr_valid && !hit_any && (wr_id != '0);

  stt_tag_store #(
    .NCHUNK(NCHUNK),
    .TAG_W (TAG_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .claim_en  (claim_en),
    .claim_mask(touched),
    .claim_id  (wr_id),
    .rel0_en   (commit_valid),
    .rel0_id   (commit_id),
    .rel1_en   (abort_valid),
    .rel1_id   (abort_id),
    .tags_flat (tag_vec_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conflict_q <= 1'b0;
      owner_q    <= '0;
    end else begin
      conflict_q <= clash_now;
      owner_q    <= clash_now ? first_owner : '0;
    end
  end

  assign conflict_o       = conflict_q;
  assign conflict_owner_o = owner_q;

  AST_OWNER_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_o |-> conflict_owner_o != '0); // R4

  AST_QUIET_OWNER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !conflict_o |-> conflict_owner_o == '0); // R9

  AST_NO_STORE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_valid) |-> !conflict_o); // R9

  AST_CLASH_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict_o && !$past(commit_valid) && !$past(abort_valid)) |-> $stable(tag_vec_o)); // R5

  AST_EMPTY_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_valid && wr_be == '0) |-> !conflict_o); // R8

endmodule

// File: tb/tb_subline_tx_tracker.sv
module tb_subline_tx_tracker;

  localparam int LB = 64;
  localparam int NC = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_valid;
  logic [1:0]    wr_id;
  logic [LB-1:0] wr_be;
  logic          commit_valid;
  logic [1:0]    commit_id;
  logic          abort_valid;
  logic [1:0]    abort_id;
  logic          conflict_o;
  logic [1:0]    conflict_owner_o;
  logic [31:0]   tag_vec_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int model [NC];

  always #4 clk = ~clk;

  subline_tx_tracker dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_id(wr_id), .wr_be(wr_be),
    .commit_valid(commit_valid), .commit_id(commit_id),
    .abort_valid(abort_valid), .abort_id(abort_id),
    .conflict_o(conflict_o), .conflict_owner_o(conflict_owner_o), .tag_vec_o(tag_vec_o)
  );

  function automatic logic [LB-1:0] ch(input int k);
    return {{(LB-4){1'b0}}, 4'hF} << (4 * k);
  endfunction

  function automatic logic [31:0] model_vec();
    logic [31:0] v = '0;
    for (int k = 0; k < NC; k++) v[2*k +: 2] = 2'(model[k]);
    return v;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus, then compare all outputs with the model.
  task automatic step(input string req, input bit wv, input int id, input logic [LB-1:0] be,
                      input bit cv, input int cid, input bit av, input int aid);
    int  own;
    bit  clash;
    @(negedge clk);
    wr_valid = wv; wr_id = 2'(id); wr_be = be;
    commit_valid = cv; commit_id = 2'(cid); abort_valid = av; abort_id = 2'(aid);
    clash = 0; own = 0;
    if (wv) begin
      for (int k = 0; k < NC; k++) begin
        if (!clash && |be[4*k +: 4] && model[k] != 0 && model[k] != id) begin
          clash = 1; own = model[k];
        end
      end
    end
    for (int k = 0; k < NC; k++) begin
      if (cv && model[k] == cid) model[k] = 0;
      if (av && model[k] == aid) model[k] = 0;
      if (wv && !clash && id != 0 && |be[4*k +: 4]) model[k] = id;
    end
    @(negedge clk);
    wr_valid = 0; commit_valid = 0; abort_valid = 0; wr_be = '0;
    check(req, "conflict", 32'(conflict_o), 32'(clash));
    check(req, "owner", 32'(conflict_owner_o), 32'(own));
    check(req, "tags", tag_vec_o, model_vec());
  endtask

  task automatic t_reset();
    check("R1", "conflict", 32'(conflict_o), 0);
    check("R1", "owner", 32'(conflict_owner_o), 0);
    check("R1", "tags", tag_vec_o, 0);
  endtask

  task automatic t_claim();
    step("R2", 1, 1, ch(3), 0, 0, 0, 0);
    check("R2", "chunk3", 32'(tag_vec_o[7:6]), 1);
    step("R2", 1, 1, ch(3) | (64'h1 << 16), 0, 0, 0, 0);
    check("R2", "chunk4", 32'(tag_vec_o[9:8]), 1);
  endtask

  task automatic t_disjoint();
    step("R3", 1, 2, ch(5), 0, 0, 0, 0);
    step("R3", 1, 3, ch(9) | ch(10), 0, 0, 0, 0);
    check("R3", "no flag", 32'(conflict_o), 0);
  endtask

  task automatic t_clash();
    step("R4", 1, 2, ch(3), 0, 0, 0, 0);
    check("R4", "owner is 1", 32'(conflict_owner_o), 1);
  endtask

  task automatic t_multi();
    step("R5", 1, 3, ch(12) | ch(5) | ch(4), 0, 0, 0, 0);
    check("R5", "lowest owner", 32'(conflict_owner_o), 1);
    check("R5", "free chunk12 kept", 32'(tag_vec_o[25:24]), 0);
  endtask

  task automatic t_registered();
    step("R9", 0, 0, '0, 0, 0, 0, 0);
    check("R9", "idle flag", 32'(conflict_o), 0);
  endtask

  task automatic t_nontx();
    step("R6", 1, 0, ch(13), 0, 0, 0, 0);
    check("R6", "no claim", 32'(tag_vec_o[27:26]), 0);
    step("R6", 1, 0, ch(13) | ch(9) | ch(5), 0, 0, 0, 0);
    check("R6", "owner 2", 32'(conflict_owner_o), 2);
  endtask

  task automatic t_empty();
    step("R8", 1, 2, '0, 0, 0, 0, 0);
  endtask

  task automatic t_same_cycle();
    step("R10", 1, 1, ch(5), 0, 0, 1, 2);
    check("R10", "owner old 2", 32'(conflict_owner_o), 2);
    check("R10", "chunk5 released", 32'(tag_vec_o[11:10]), 0);
    step("R10", 1, 3, ch(9) | ch(14), 0, 0, 1, 3);
    check("R10", "claim beats release", 32'(tag_vec_o[19:18]), 3);
  endtask

  task automatic t_release();
    step("R7", 0, 0, '0, 1, 1, 0, 0);
    check("R7", "id1 gone", 32'(tag_vec_o[9:6]), 0);
    step("R7", 1, 2, ch(0) | ch(1), 0, 0, 0, 0);
    step("R7", 0, 0, '0, 1, 2, 1, 3);
    check("R7", "all clear", tag_vec_o, 0);
  endtask

  initial begin
    for (int k = 0; k < NC; k++) model[k] = 0;
    rst_n = 0; wr_valid = 0; wr_id = 0; wr_be = '0;
    commit_valid = 0; commit_id = 0; abort_valid = 0; abort_id = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_claim();
    t_disjoint();
    t_clash();
    t_multi();
    t_registered();
    t_nontx();
    t_empty();
    t_same_cycle();
    t_release();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule